// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 31 on-chip peripherals and turns them into a single request towards the host CPU. Each source has a vector number from 1 to 31. Vector 0 is reserved as the error vector. Software programs an enable bit, a choice of CPU interrupt line and a per-source mask. When the CPU takes the interrupt, it performs an acknowledge: first a write, then a read of the vector register. That read returns the number of the winning source. The source stays marked in service until software clears it. While it is in service, sources of lower or equal priority are held off.

A small state machine sequences the handshake. It has three states:

- ST_IDLE: no request is driven.
- ST_RAISE: the selected CPU line is driven.
- ST_HOLD: a vector is latched and waits to be read.

The state machine has five named transitions:

- IDLE→RAISE (*raise*): taken when the controller is enabled and a source is eligible.
- RAISE→IDLE (*drop*): taken when the global enable is cleared.
- IDLE→HOLD and RAISE→HOLD (*ack*): taken on an acknowledge write.
- HOLD→IDLE (*release*): taken when the vector register is read.

If the request has been withdrawn or masked by the time of the acknowledge, the vector latched is the error vector 0.

Top module: `vpic_top`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers all read 0, and `cpu_irq` is 0.
- R2: Mask register (address 1) bit v enables source v (1 to 31). A source whose bit is 0 never raises the CPU request and never wins an acknowledge. Bit 0 reads 0.
- R3: Configuration register (address 0) bit 7 is the global enable. While it is 0, `cpu_irq` stays 0. Once it is set with an eligible source pending, the request appears on the second rising edge after the set.
- R4: Configuration bits 15:13 select which of the 8 `cpu_irq` lines is driven. At most one line is high at any time.
- R5: Fixed priority: among sources that are pending, unmasked and eligible, the highest vector number wins.
- R6: Writing 1 to bit 0 of the vector register (address 3) is an acknowledge. It latches the winner, which is then read in bits 15:11 with all other bits 0. It sets the winner's in-service bit (address 2, bit = vector) and drops `cpu_irq`.
- R7: The in-service register is write-one-to-clear. Bits written as 0 keep their value.
- R8: While any source is in service, only sources with a higher vector number than the highest in-service vector may raise a request. Clearing the in-service bit lets the lower source through.
- R9: If no source is eligible at the acknowledge edge, the latched vector is 0 and no in-service bit is set. This covers a request that was withdrawn or masked after the CPU request, including a withdrawal in the same cycle as the acknowledge.
- R10: In ST_HOLD, `cpu_irq` is 0 and a further acknowledge write is ignored. Reading the vector register (with `bus_rd`) returns to ST_IDLE, after which a pending eligible source raises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 31 | Level requests, bit v is source vector v (range 31:1) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only on the vector register) |
| bus_addr | input | 2 | Register select: 0 configuration, 1 mask, 2 in-service, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 8 | CPU interrupt lines, one selected by the level field |

## Verification
Two events can fall on the same clock edge: the acknowledge write and a change in the very request being acknowledged. The bench drops the only pending source in the same cycle as the acknowledge write. It then expects vector 0 and an unchanged in-service register, because the acknowledge judges the request levels present at that edge. A second overlap is a higher source arriving while a vector waits in ST_HOLD. The bench checks that this source stays silent until the vector read, and that it then preempts the source already in service.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAISE = 2'd1,
        ST_HOLD  = 2'd2
    } vpic_state_e;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_MSK = 2'd1;
    localparam logic [1:0] ADDR_ISR = 2'd2;
    localparam logic [1:0] ADDR_VEC = 2'd3;

    localparam int CFG_EN_BIT  = 7;
    localparam int CFG_LVL_LSB = 13;
    localparam int VEC_LSB     = 11;
    localparam int ACK_BIT     = 0;

endpackage

// File: rtl/vpic_prio_enc.sv
// Highest-index set bit finder.
module vpic_prio_enc #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vpic_gate.sv
// Per-source eligibility: pending, unmasked, not in service, above the service level.
module vpic_gate #(
    parameter int NSRC = 31,
    parameter int VW   = 5
) (
    input  logic [NSRC:1] src,
    input  logic [NSRC:1] mask,
    input  logic [NSRC:1] isr,
    input  logic [VW-1:0] isr_top,
    input  logic          isr_any,
    output logic [NSRC:1] elig
);
    for (genvar v = 1; v <= NSRC; v++) begin : g_src
        assign elig[v] = src[v] & mask[v] & ~isr[v] &
                         (~isr_any | (VW'(v) > isr_top));
    end
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NSRC = 31,
    parameter int VW   = 5,
    parameter int LVLW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [1:0]      addr,
    input  logic [31:0]     wdata,
    input  logic            ack_set,
    input  logic [VW-1:0]   ack_vec,
    output logic            cfg_en,
    output logic [LVLW-1:0] cfg_lvl,
    output logic [NSRC:1]   mask,
    output logic [NSRC:1]   isr
);
    logic            en_q;
    logic [LVLW-1:0] lvl_q;
    logic [NSRC:1]   mask_q;
    logic [NSRC:1]   isr_q;
    logic [NSRC:1]   isr_d;
    logic            unused_wd0;

    assign unused_wd0 = wdata[0];

    always_comb begin
        isr_d = isr_q;
        if (wr && addr == ADDR_ISR) begin
            isr_d = isr_q & ~wdata[NSRC:1];
        end
        if (ack_set) begin
            for (int v = 1; v <= NSRC; v++) begin
                if (ack_vec == VW'(v)) begin
                    isr_d[v] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lvl_q  <= '0;
            mask_q <= '0;
            isr_q  <= '0;
        end else begin
            if (wr && addr == ADDR_CFG) begin
                en_q  <= wdata[CFG_EN_BIT];
                lvl_q <= wdata[CFG_LVL_LSB +: LVLW];
            end
            if (wr && addr == ADDR_MSK) begin
                mask_q <= wdata[NSRC:1];
            end
            isr_q <= isr_d;
        end
    end

    assign cfg_en  = en_q;
    assign cfg_lvl = lvl_q;
    assign mask    = mask_q;
    assign isr     = isr_q;

    // R7: after an in-service write, every bit written as 1 reads cleared
    p_isr_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_ISR) |=> ((isr_q & $past(wdata[NSRC:1])) == '0));

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     irq_src,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NLINES-1:0] cpu_irq
);
    localparam int VW   = $clog2(NSRC + 1);
    localparam int LVLW = $clog2(NLINES);
    localparam int VECN = NSRC + 1;
    localparam logic [VW-1:0] ERR_VEC = '0;

    vpic_state_e     st_q, st_d;
    logic [VW-1:0]   vec_q;
    logic            cfg_en;
    logic [LVLW-1:0] cfg_lvl;
    logic [NSRC:1]   mask, isr, elig;
    logic [VW-1:0]   isr_top, win_idx;
    logic            isr_any, win_any;
    logic            ack;
    logic            vec_read;

    assign ack      = bus_wr && bus_addr == ADDR_VEC && bus_wdata[ACK_BIT]
                      && st_q != ST_HOLD;
    assign vec_read = bus_rd && bus_addr == ADDR_VEC;

    vpic_regs #(.NSRC(NSRC), .VW(VW), .LVLW(LVLW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ack_set (ack && win_any),
        .ack_vec (win_idx),
        .cfg_en  (cfg_en),
        .cfg_lvl (cfg_lvl),
        .mask    (mask),
        .isr     (isr)
    );

    vpic_prio_enc #(.W(VECN), .IW(VW)) u_isr_enc (
        .req ({isr, 1'b0}),
        .idx (isr_top),
        .any (isr_any)
    );

    vpic_gate #(.NSRC(NSRC), .VW(VW)) u_gate (
        .src     (irq_src),
        .mask    (mask),
        .isr     (isr),
        .isr_top (isr_top),
        .isr_any (isr_any),
        .elig    (elig)
    );

    vpic_prio_enc #(.W(VECN), .IW(VW)) u_win_enc (
        .req ({elig, 1'b0}),
        .idx (win_idx),
        .any (win_any)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ack)                     st_d = ST_HOLD;
                else if (cfg_en && win_any)  st_d = ST_RAISE;
            end
            ST_RAISE: begin
                if (ack)                     st_d = ST_HOLD;
                else if (!cfg_en)            st_d = ST_IDLE;
            end
            ST_HOLD: begin
                if (vec_read)                st_d = ST_IDLE;
            end
            default:                         st_d = ST_IDLE;
        endcase
    end

    // state and vector registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            vec_q <= '0;
        end else begin
            st_q <= st_d;
            if (ack) begin
                vec_q <= win_any ? win_idx : ERR_VEC;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_irq = '0;
        if (st_q == ST_RAISE) begin
            cpu_irq[cfg_lvl] = 1'b1;
        end
        unique case (bus_addr)
            ADDR_CFG: bus_rdata = 32'({cfg_lvl, 5'b0, cfg_en, 7'b0});
            ADDR_MSK: bus_rdata = 32'({mask, 1'b0});
            ADDR_ISR: bus_rdata = 32'({isr, 1'b0});
            default:  bus_rdata = 32'({vec_q, {VEC_LSB{1'b0}}});
        endcase
    end

    // R4: never more than one CPU line at once
    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_irq));

    // R3: the request state is only reached with the global enable set
    p_raise_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RAISE) |-> $past(cfg_en));

    // R6: an acknowledge with a winner marks that winner in service
    p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && win_any) |=> ({isr, 1'b0} >> $past(win_idx)) & 1);

    // R9: an acknowledge with nothing eligible latches the error vector
    p_err_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !win_any) |=> (st_q == ST_HOLD && vec_q == ERR_VEC));

    // R8: a winner always ranks above everything in service
    p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_any && isr_any) |-> (win_idx > isr_top));

    // R10: no CPU request while a vector waits to be read
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |-> (cpu_irq == '0));

endmodule

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] irq_src = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cpu_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vpic_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    // table: source levels (bit = vector), mask, expected vector (0 = error)
    localparam int NT = 8;
    localparam logic [31:0] T_SRC [NT] = '{32'h0000_0002, 32'h8000_0000,
        32'h0001_0100, 32'h0001_0100, 32'hF0F0_F0F0, 32'h0000_0040,
        32'h0000_0000, 32'hAAAA_AAAA};
    localparam logic [31:0] T_MSK [NT] = '{32'hFFFF_FFFE, 32'hFFFF_FFFE,
        32'hFFFF_FFFE, 32'h0000_0100, 32'h0F0F_FFFE, 32'h0000_0000,
        32'hFFFF_FFFE, 32'h2000_0000};
    localparam logic [4:0] T_VEC [NT] = '{5'd1, 5'd31, 5'd16, 5'd8, 5'd15,
        5'd0, 5'd0, 5'd29};

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic brd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], d);
            chk("R1 reset register", d, 32'h0);
        end
        chk("R1 reset cpu_irq", {24'h0, cpu_irq}, 32'h0);

        // table walk: R2 R4 R5 R6 R9
        for (int i = 0; i < NT; i++) begin
            int lvl;
            lvl = i % 8;
            bwr(2'd0, 32'h80 | (lvl << 13));
            bwr(2'd1, T_MSK[i]);
            irq_src = T_SRC[i][31:1];
            @(negedge clk);
            @(negedge clk);
            chk("R4/R5 cpu line", {24'h0, cpu_irq},
                (T_VEC[i] != 0) ? (32'h1 << lvl) : 32'h0);
            bwr(2'd3, 32'h1);
            chk("R6 line drops after ack", {24'h0, cpu_irq}, 32'h0);
            brd(2'd3, d);
            chk("R5/R9 vector", d, {16'h0, T_VEC[i], 11'h0});
            peek(2'd2, d);
            chk("R6 in-service set", d, (T_VEC[i] != 0) ? (32'h1 << T_VEC[i]) : 32'h0);
            irq_src = '0;
            bwr(2'd0, 32'h0);
            bwr(2'd1, 32'h0);
            bwr(2'd2, 32'hFFFF_FFFF);
            @(negedge clk);
        end

        // R3: global enable gates the request
        bwr(2'd1, 32'hFFFF_FFFE);
        irq_src = '0; irq_src[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 disabled stays quiet", {24'h0, cpu_irq}, 32'h0);
        peek(2'd0, d);
        chk("R3 config readback", d, 32'h0);
        bwr(2'd0, 32'h0000_4080);          // enable, line 2
        peek(2'd0, d);
        chk("R3 config readback enabled", d, 32'h0000_4080);
        @(negedge clk);
        chk("R3 request after enable", {24'h0, cpu_irq}, 32'h4);

        // R10: hold state, higher arrival waits, second ack ignored
        irq_src[9] = 1'b1;
        bwr(2'd3, 32'h1);                   // wins 9
        irq_src[20] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 quiet in hold", {24'h0, cpu_irq}, 32'h0);
        bwr(2'd3, 32'h1);                   // ignored
        peek(2'd3, d);
        chk("R10 vector kept", d, {16'h0, 5'd9, 11'h0});
        peek(2'd2, d);
        chk("R10 second ack sets nothing", d, 32'h1 << 9);
        brd(2'd3, d);
        chk("R10 read returns 9", d, {16'h0, 5'd9, 11'h0});
        @(negedge clk);
        chk("R8 higher source preempts", {24'h0, cpu_irq}, 32'h4);
        bwr(2'd3, 32'h1);
        brd(2'd3, d);
        chk("R8 nested vector 20", d, {16'h0, 5'd20, 11'h0});
        repeat (2) @(negedge clk);
        chk("R8 lower source held off", {24'h0, cpu_irq}, 32'h0);

        // R7: write-one-to-clear
        bwr(2'd2, 32'h0);
        peek(2'd2, d);
        chk("R7 zero write keeps bits", d, (32'h1 << 9) | (32'h1 << 20));
        irq_src[20] = 1'b0;
        bwr(2'd2, 32'h1 << 20);
        peek(2'd2, d);
        chk("R7 clear one bit", d, 32'h1 << 9);
        repeat (2) @(negedge clk);
        chk("R8 still below 9", {24'h0, cpu_irq}, 32'h0);
        irq_src[9] = 1'b0;
        bwr(2'd2, 32'h1 << 9);
        @(negedge clk);
        chk("R8 released lower source", {24'h0, cpu_irq}, 32'h4);

        // R9: source withdrawn in the same cycle as the acknowledge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h1;
        irq_src[5] = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        brd(2'd3, d);
        chk("R9 withdrawn gives error vector", d, 32'h0);
        peek(2'd2, d);
        chk("R9 no in-service bit", d, 32'h0);
        @(negedge clk);
        chk("R9 line idle", {24'h0, cpu_irq}, 32'h0);

        // R2: bit 0 of the mask is not a source
        bwr(2'd1, 32'hFFFF_FFFF);
        peek(2'd1, d);
        chk("R2 mask bit 0 reads 0", d, 32'hFFFF_FFFE);

        summary();
    end
endmodule